// File: doc/BRIEF.md
# Key-Sequence Register Unlock Gate

This block guards the counting and writable registers of a time-keeping core. After reset it holds the core locked. It watches the register write strobes that the bus presents to the core. It opens the core only when seven key writes have landed in ascending address order, each key going to its own address with its own value. While the gate is closed, the core must not count and must not take register writes. Once the gate opens, it stays open until the next reset.

A write to a key address that carries the wrong value, or that arrives out of turn, sends progress back to the start. The exception is the first key: writing it correctly always restarts progress at step one. Writes to any other address do not disturb progress. Every key address also holds the last value written to it, so software can read its key writes back.

The bus port is a plain strobe interface: one write and one read may be presented per cycle, and neither side is ever stalled. No back-pressure exists, so every strobe is taken on the clock edge where it is high. After unlocking, software clears the debounce setting and the stop bit of the core through the gated write strobe `core_wr_en`.

Top module: `ulk_gate`

## Requirements
- R1: After reset, `unlocked` is 0, `rd_data` is 0, and every key address reads back 0.
- R2: The key pairs (address, value) are (0x04,0xC6), (0x08,0x9A), (0x0C,0x59), (0x10,0xA3), (0x14,0x57), (0x18,0x67) and (0x1C,0xD2), and they must be written in that order. `unlocked` is first seen high after the clock edge that takes the seventh correct write.
- R3: While locked, a write to a key address with the wrong value, or to a key address other than the next expected one, returns progress to the start. The case in R4 is the exception.
- R4: While locked, writing 0xC6 to 0x04 restarts progress at step one from any state, so that 0x08/0x9A is the next key expected.
- R5: While locked, a write to a non-key address leaves progress unchanged. Key addresses are matched on all address bits, so 0x05 is not a key address.
- R6: Once high, `unlocked` stays high until reset, whatever is later written to the key addresses.
- R7: `core_wr_en` is high in the same cycle as `wr_en` exactly when the gate is unlocked and `wr_addr` is not a key address. Otherwise it is low.
- R8: When `rd_en` is high, `rd_data` shows a value after the next clock edge and then holds until the next read. A key address returns the last value written to it, in any lock state. A write in the same cycle as the read is not yet visible to that read. A non-key address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, taken on every edge where it is high |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write value |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Read value, registered |
| unlocked | output | 1 | High once the full key sequence has been accepted; enables counting |
| core_wr_en | output | 1 | Write strobe passed through to the core |

## Verification
`core_wr_en` is combinational, so the bench checks it 1 ns after it drives the inputs at the falling edge, within the same cycle. `unlocked` and `rd_data` each pass through one register. The bench therefore checks them 1 ns after the rising edge that takes the stimulus. At that point its behavioural model has applied the same write and read. Every cycle is compared this way. Directed checks then confirm the lock state at the end of each sequence scenario.

// File: rtl/ulk_pkg.sv
package ulk_pkg;
  localparam int NKEYS      = 7;
  localparam int KEY_BASE   = 4;
  localparam int KEY_STRIDE = 4;
  localparam int IDX_W      = $clog2(NKEYS);
  localparam int STEP_W     = $clog2(NKEYS + 1);

  function automatic logic [7:0] key_val(input int unsigned i);
    case (i)
      0: key_val = 8'hC6;
      1: key_val = 8'h9A;
      2: key_val = 8'h59;
      3: key_val = 8'hA3;
      4: key_val = 8'h57;
      5: key_val = 8'h67;
      6: key_val = 8'hD2;
      default: key_val = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ulk_key_decode.sv
module ulk_key_decode
  import ulk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_key,
  output logic [IDX_W-1:0]  idx
);
  logic [NKEYS-1:0] hit;

  for (genvar g = 0; g < NKEYS; g++) begin : g_hit
    assign hit[g] = (addr == ADDR_W'(KEY_BASE + KEY_STRIDE * g));
  end

  assign is_key = |hit;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NKEYS; i++) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ulk_progress.sv
module ulk_progress
  import ulk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [IDX_W-1:0] key_idx,
  input  logic             val_ok,
  output logic             unlocked
);
  logic [STEP_W-1:0] step_q, step_d;
  logic              done;

  assign done     = (step_q == STEP_W'(NKEYS));
  assign unlocked = done;

  always_comb begin
    step_d = step_q;
    if (key_wr && !done) begin
      if (key_idx == '0 && val_ok)
        step_d = STEP_W'(1);
      else if (STEP_W'(key_idx) == step_q && val_ok)
        step_d = step_q + STEP_W'(1);
      else
        step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !unlocked && key_idx == '0 && val_ok) |=> (step_q == STEP_W'(1)));

  p_wrong_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !unlocked && !val_ok) |=> (step_q == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(step_q));
endmodule

// File: rtl/ulk_shadow.sv
module ulk_shadow
  import ulk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_is_key,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sh_q [NKEYS];
  logic [DATA_W-1:0] rd_mux;

  for (genvar g = 0; g < NKEYS; g++) begin : g_sh
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    sh_q[g] <= '0;
      else if (key_wr && wr_idx == IDX_W'(g))        sh_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NKEYS; i++) begin
      if (rd_is_key && rd_idx == IDX_W'(i)) rd_mux = sh_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  p_nonkey_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_is_key) |=> (rd_data == '0));

  p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/ulk_gate.sv
module ulk_gate
  import ulk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              unlocked,
  output logic              core_wr_en
);
  logic             wr_is_key, rd_is_key, key_wr, val_ok;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  ulk_key_decode #(.ADDR_W(ADDR_W)) u_wr_dec (
    .addr(wr_addr), .is_key(wr_is_key), .idx(wr_idx)
  );

  ulk_key_decode #(.ADDR_W(ADDR_W)) u_rd_dec (
    .addr(rd_addr), .is_key(rd_is_key), .idx(rd_idx)
  );

  assign key_wr = wr_en && wr_is_key;
  assign val_ok = (wr_data == DATA_W'(key_val(int'(wr_idx))));

  ulk_progress u_prog (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_idx(wr_idx),
    .val_ok(val_ok), .unlocked(unlocked)
  );

  ulk_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_en(rd_en), .rd_is_key(rd_is_key),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  assign core_wr_en = wr_en && unlocked && !wr_is_key;

  p_unlock_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_en && wr_addr == ADDR_W'(8'h1C)
                              && wr_data == DATA_W'(8'hD2)));

  p_locked_no_core_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_en) |-> !core_wr_en);
endmodule

// File: tb/test_ulk_gate.sv
`timescale 1ns/1ps
module test_ulk_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic       unlocked, core_wr_en;

  int checks = 0;
  int errors = 0;

  int         m_step;
  logic [7:0] m_sh [7];
  logic [7:0] m_rd;
  logic [7:0] kval [7] = '{8'hC6, 8'h9A, 8'h59, 8'hA3, 8'h57, 8'h67, 8'hD2};

  always #4 clk = ~clk;

  ulk_gate i_ulk_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .unlocked(unlocked), .core_wr_en(core_wr_en)
  );

  function automatic int kidx(input logic [7:0] a);
    for (int i = 0; i < 7; i++) if (a == 8'(4 + 4 * i)) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_step = 0;
    m_rd   = '0;
    for (int i = 0; i < 7; i++) m_sh[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d,
                     input logic re, input logic [7:0] ra);
    int  ki, ri;
    logic exp_core;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; rd_en = re; rd_addr = ra;
    #1;
    ki = kidx(a);
    ri = kidx(ra);
    exp_core = we && (m_step == 7) && (ki < 0);
    check(core_wr_en === exp_core, "R7 core_wr_en", 32'(core_wr_en), 32'(exp_core));
    if (re) m_rd = (ri >= 0) ? m_sh[ri] : 8'h00;
    if (we && ki >= 0) begin
      m_sh[ki] = d;
      if (m_step != 7) begin
        if (ki == 0 && d == kval[0])              m_step = 1;
        else if (ki == m_step && d == kval[ki])   m_step = m_step + 1;
        else                                      m_step = 0;
      end
    end
    @(posedge clk);
    #1;
    check(unlocked === (m_step == 7), "R2 unlocked per-cycle",
          32'(unlocked), 32'(m_step == 7));
    check(rd_data === m_rd, "R8 rd_data per-cycle", 32'(rd_data), 32'(m_rd));
  endtask

  task automatic wkey(input int i);
    cyc(1'b1, 8'(4 + 4 * i), kval[i], 1'b0, 8'h00);
  endtask

  task automatic idle();
    cyc(1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    #1;
    // R1 reset state
    check(unlocked === 1'b0, "R1 unlocked after reset", 32'(unlocked), 0);
    check(rd_data === 8'h00, "R1 rd_data after reset", 32'(rd_data), 0);
    for (int i = 0; i < 7; i++) cyc(1'b0, 8'h00, 8'h00, 1'b1, 8'(4 + 4 * i));
    check(rd_data === 8'h00, "R1 key readback after reset", 32'(rd_data), 0);

    // R7 locked: non-key write does not pass
    cyc(1'b1, 8'h20, 8'h01, 1'b0, 8'h00);

    // R3 wrong value at the fourth pair
    for (int i = 0; i < 3; i++) wkey(i);
    cyc(1'b1, 8'h10, 8'hA4, 1'b0, 8'h00);
    for (int i = 3; i < 7; i++) wkey(i);
    check(unlocked === 1'b0, "R3 wrong value resets progress", 32'(unlocked), 0);

    // R3 out of order
    wkey(0); wkey(1); wkey(3);
    for (int i = 2; i < 7; i++) wkey(i);
    check(unlocked === 1'b0, "R3 out-of-order resets progress", 32'(unlocked), 0);

    // R8 readback and same-cycle write invisibility
    cyc(1'b1, 8'h14, 8'h3C, 1'b1, 8'h14);
    cyc(1'b0, 8'h00, 8'h00, 1'b1, 8'h14);
    check(rd_data === 8'h3C, "R8 key readback", 32'(rd_data), 32'h3C);
    cyc(1'b0, 8'h00, 8'h00, 1'b1, 8'h2C);
    check(rd_data === 8'h00, "R8 non-key read", 32'(rd_data), 0);

    // R4 restart in the middle
    wkey(0); wkey(1); wkey(2); wkey(0);
    for (int i = 1; i < 7; i++) wkey(i);
    check(unlocked === 1'b1, "R4 restart then full sequence unlocks", 32'(unlocked), 1);

    // R6 sticky
    cyc(1'b1, 8'h04, 8'h00, 1'b0, 8'h00);
    cyc(1'b1, 8'h1C, 8'h11, 1'b0, 8'h00);
    idle();
    check(unlocked === 1'b1, "R6 stays unlocked", 32'(unlocked), 1);

    // R7 unlocked pass-through and key blocking
    cyc(1'b1, 8'h2C, 8'h00, 1'b0, 8'h00);
    cyc(1'b1, 8'h20, 8'h00, 1'b0, 8'h00);
    cyc(1'b1, 8'h08, 8'h55, 1'b1, 8'h1C);
    check(rd_data === 8'h11, "R8 readback while unlocked", 32'(rd_data), 32'h11);

    // R1 relock on reset
    do_reset();
    #1;
    check(unlocked === 1'b0, "R1 relocked after reset", 32'(unlocked), 0);

    // R5 interleaved non-key writes
    wkey(0);
    cyc(1'b1, 8'h05, 8'h9A, 1'b0, 8'h00);
    wkey(1);
    cyc(1'b1, 8'h00, 8'hFF, 1'b0, 8'h00);
    cyc(1'b1, 8'h2C, 8'h00, 1'b0, 8'h00);
    for (int i = 2; i < 6; i++) begin
      wkey(i);
      cyc(1'b1, 8'h40, 8'h59, 1'b1, 8'h0C);
    end
    check(unlocked === 1'b0, "R5 not yet unlocked", 32'(unlocked), 0);
    wkey(6);
    check(unlocked === 1'b1, "R5 non-key writes keep progress", 32'(unlocked), 1);
    idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule